// File: doc/BRIEF.md
# Memory Map Decoder With Access Checks

This block turns a 24-bit byte address issued by one of several bus masters into a one-hot target select. The possible targets are the register window at the bottom of the map, the dual-access RAM, the single-access RAM, the boot ROM and five external chip-select spaces. For the two RAM targets it also reports which 4K-word block the address falls in, counted from the start of that RAM, so the RAM wrapper can pick a bank without a second decode.

Each request carries a master identifier. The decoder checks whether that master is allowed to reach the decoded target. A forbidden access raises an error flag for one cycle and drives no select at all.

A single control bit, written through a one-bit write port, moves the top 128 KB from the internal ROM to the highest external chip select. Hardware reset clears this bit. Software reset clears only the decoder outputs and keeps the bit.

Results are registered one cycle after the request. A request is taken in every cycle it is presented. There is no back-pressure, so the request strobe works as a valid with an always-ready sink.

Top module: `mmap_decode`

## Requirements
- R1: A granted request selects exactly one target. The one-hot select bits are: bit0 register window (0x000000–0x0000BF), bit1 dual-access RAM (0x0000C0–0x00FFFF), bit2 single-access RAM (0x010000–0x04FFFF), bit3 internal ROM, bit4 CS0 (from 0x050000), bit5 CS2 (from 0x800000), bit6 CS3 (from 0xC00000), bit7 CS4 (from 0xE00000), bit8 CS5 (from 0xF00000).
- R2: Addresses 0xFE0000–0xFFFFFF select the internal ROM (bit3) while the ROM-disable bit is 0, and select CS5 (bit8) while it is 1.
- R3: The block index is the byte offset inside the selected RAM divided by 8192: 0–7 for dual-access RAM and 0–31 for single-access RAM. It is 0 for every other target, for errors and when idle.
- R4: Outputs appear on the first clock edge after the request. In a cycle without a request, the next cycle shows no select, no error and index 0.
- R5: DMA controllers 0–2 (IDs 1–3) get an error and no select for any external target, including the ROM window while it is remapped to CS5. They may reach the register window, both RAMs and the internal ROM.
- R6: USB (ID 5) and LCD (ID 6) get an error and no select for dual-access RAM. They may reach single-access RAM, the register window and the other targets.
- R7: The CPU (ID 0) and DMA controller 3 (ID 4) may reach every target. The unused ID 7 gets an error for every address.
- R8: Hardware reset (hw_rst_n low, asynchronous) clears the ROM-disable bit and all outputs. It wins over a ROM-disable write in the same cycle.
- R9: Software reset (sw_rst high, synchronous) clears all outputs on the next edge, even if a request is present. It leaves the ROM-disable bit unchanged.
- R10: A ROM-disable write is applied at the clock edge. A request in the same cycle as the write is decoded with the old value, and later requests use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| req | input | 1 | Request strobe; one decode per cycle while high |
| master_id | input | 3 | Requesting master: 0 CPU, 1–4 DMA0–3, 5 USB, 6 LCD, 7 unused |
| addr | input | 24 | Byte address |
| rom_dis_we | input | 1 | Write enable for the ROM-disable bit |
| rom_dis_wdata | input | 1 | Value written to the ROM-disable bit |
| sel | output | 9 | Registered one-hot target select |
| blk_idx | output | 5 | Registered RAM block index |
| acc_err | output | 1 | Registered access-error flag |

## Verification
The bench builds the decoder with its default parameters: eight dual-access and thirty-two single-access blocks of 8 KB, a 192-byte register window, and the default chip-select bases. These values put the edges of every region within reach, as well as the first and last block index of each RAM. With the bench driving each master ID, every grant rule can be exercised against every kind of target. The directed part covers the ROM window under both values of the disable bit and the ordering of same-cycle write, request and the two resets.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  typedef enum logic [2:0] {
    MST_CPU  = 3'd0,
    MST_DMA0 = 3'd1,
    MST_DMA1 = 3'd2,
    MST_DMA2 = 3'd3,
    MST_DMA3 = 3'd4,
    MST_USB  = 3'd5,
    MST_LCD  = 3'd6,
    MST_RSVD = 3'd7
  } master_e;

  typedef enum logic [3:0] {
    TGT_MMR   = 4'd0,
    TGT_DARAM = 4'd1,
    TGT_SARAM = 4'd2,
    TGT_ROM   = 4'd3,
    TGT_CS0   = 4'd4,
    TGT_CS2   = 4'd5,
    TGT_CS3   = 4'd6,
    TGT_CS4   = 4'd7,
    TGT_CS5   = 4'd8
  } target_e;

  localparam int NUM_TGT = 9;
  localparam int NUM_EXT = 5;

  function automatic logic is_external(target_e t);
    return (t >= TGT_CS0);
  endfunction

endpackage

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
  import mmap_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 5,
  parameter int BLK_LOG2   = 13,
  parameter int MMR_BYTES  = 192,
  parameter int DARAM_BLKS = 8,
  parameter int SARAM_BLKS = 32,
  parameter logic [ADDR_W-1:0] CS0_BASE = 24'h050000,
  parameter logic [ADDR_W-1:0] CS2_BASE = 24'h800000,
  parameter logic [ADDR_W-1:0] CS3_BASE = 24'hC00000,
  parameter logic [ADDR_W-1:0] CS4_BASE = 24'hE00000,
  parameter logic [ADDR_W-1:0] CS5_BASE = 24'hF00000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hFE0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_dis,
  output target_e           tgt,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] MMR_END   = ADDR_W'(MMR_BYTES);
  localparam logic [ADDR_W-1:0] DARAM_END = ADDR_W'(DARAM_BLKS << BLK_LOG2);
  localparam logic [ADDR_W-1:0] SARAM_END = ADDR_W'((DARAM_BLKS + SARAM_BLKS) << BLK_LOG2);
  localparam logic [ADDR_W-1:0] EXT_BASE [NUM_EXT] =
    '{CS0_BASE, CS2_BASE, CS3_BASE, CS4_BASE, CS5_BASE};

  logic [NUM_EXT-1:0] ext_hit;

  generate
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
      assign ext_hit[g] = (addr >= EXT_BASE[g]);
    end
  endgenerate

  logic [ADDR_W-1:0] sa_off;
  assign sa_off = addr - DARAM_END;

  always_comb begin
    tgt = TGT_MMR;
    idx = '0;
    if (addr < MMR_END) begin
      tgt = TGT_MMR;
    end else if (addr < DARAM_END) begin
      tgt = TGT_DARAM;
      idx = IDX_W'(addr >> BLK_LOG2);
    end else if (addr < SARAM_END) begin
      tgt = TGT_SARAM;
      idx = IDX_W'(sa_off >> BLK_LOG2);
    end else if (addr >= ROM_BASE) begin
      tgt = rom_dis ? TGT_CS5 : TGT_ROM;
    end else begin
      tgt = TGT_CS0;
      for (int i = 0; i < NUM_EXT; i++) begin
        if (ext_hit[i]) tgt = target_e'(4'(int'(TGT_CS0) + i));
      end
    end
  end

endmodule

// File: rtl/mmap_access_chk.sv
module mmap_access_chk
  import mmap_pkg::*;
(
  input  logic [2:0] master_id,
  input  target_e    tgt,
  output logic       allowed
);

  master_e mst;
  assign mst = master_e'(master_id);

  always_comb begin
    unique case (mst)
      MST_CPU, MST_DMA3:           allowed = 1'b1;
      MST_DMA0, MST_DMA1, MST_DMA2: allowed = !is_external(tgt);
      MST_USB, MST_LCD:            allowed = (tgt != TGT_DARAM);
      default:                     allowed = 1'b0;
    endcase
  end

endmodule

// File: rtl/mmap_rom_ctl.sv
module mmap_rom_ctl (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic we,
  input  logic wdata,
  output logic rom_dis
);

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) rom_dis <= 1'b0;
    else if (we)   rom_dis <= wdata;
  end

endmodule

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BLK_LOG2   = 13,
  parameter int MMR_BYTES  = 192,
  parameter int DARAM_BLKS = 8,
  parameter int SARAM_BLKS = 32
) (
  input  logic                 clk,
  input  logic                 hw_rst_n,
  input  logic                 sw_rst,
  input  logic                 req,
  input  logic [2:0]           master_id,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rom_dis_we,
  input  logic                 rom_dis_wdata,
  output logic [NUM_TGT-1:0]   sel,
  output logic [$clog2(SARAM_BLKS > DARAM_BLKS ? SARAM_BLKS : DARAM_BLKS)-1:0] blk_idx,
  output logic                 acc_err
);

  localparam int IDX_W = $clog2(SARAM_BLKS > DARAM_BLKS ? SARAM_BLKS : DARAM_BLKS);

  logic             rom_dis;
  target_e          tgt;
  logic [IDX_W-1:0] idx;
  logic             allowed;
  logic             grant;
  logic [NUM_TGT-1:0] sel_d;

  mmap_rom_ctl u_rom (
    .clk      (clk),
    .hw_rst_n (hw_rst_n),
    .we       (rom_dis_we),
    .wdata    (rom_dis_wdata),
    .rom_dis  (rom_dis)
  );

  mmap_region_dec #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .BLK_LOG2   (BLK_LOG2),
    .MMR_BYTES  (MMR_BYTES),
    .DARAM_BLKS (DARAM_BLKS),
    .SARAM_BLKS (SARAM_BLKS)
  ) u_dec (
    .addr    (addr),
    .rom_dis (rom_dis),
    .tgt     (tgt),
    .idx     (idx)
  );

  mmap_access_chk u_acc (
    .master_id (master_id),
    .tgt       (tgt),
    .allowed   (allowed)
  );

  assign grant = req && allowed;

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
      assign sel_d[t] = grant && (tgt == target_e'(4'(t)));
    end
  endgenerate

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      sel     <= '0;
      blk_idx <= '0;
      acc_err <= 1'b0;
    end else if (sw_rst) begin
      sel     <= '0;
      blk_idx <= '0;
      acc_err <= 1'b0;
    end else begin
      sel     <= sel_d;
      blk_idx <= grant ? idx : '0;
      acc_err <= req && !allowed;
    end
  end

endmodule

// File: rtl/mmap_decode_chk.sv
module mmap_decode_chk
  import mmap_pkg::*;
(
  input logic               clk,
  input logic               hw_rst_n,
  input logic               sw_rst,
  input logic               req,
  input logic [2:0]         master_id,
  input logic [23:0]        addr,
  input logic               rom_dis_we,
  input logic               rom_dis,
  input logic [NUM_TGT-1:0] sel,
  input logic [4:0]         blk_idx,
  input logic               acc_err
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $onehot0(sel)) else $error("sel not one-hot"); // R1

  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!hw_rst_n)
    acc_err |-> (sel == '0)) else $error("select during error"); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !req |=> (sel == '0 && !acc_err && blk_idx == '0)) else $error("output without request"); // R4

  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_rst |=> (sel == '0 && !acc_err)) else $error("software reset ignored"); // R9

  AST_ROM_KEEP: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && !rom_dis_we) |=> $stable(rom_dis)) else $error("rom bit changed"); // R9

  AST_DMA_EXT_ERR: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (req && !sw_rst && master_id >= 3'd1 && master_id <= 3'd3 &&
     addr >= 24'h050000 && addr < 24'hFE0000) |=> acc_err) else $error("dma external granted"); // R5

  AST_USB_DARAM_ERR: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (req && !sw_rst && (master_id == 3'd5 || master_id == 3'd6) &&
     addr >= 24'h0000C0 && addr < 24'h010000) |=> acc_err) else $error("usb/lcd dual ram granted"); // R6

  AST_CPU_GRANT: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (req && !sw_rst && master_id == 3'd0) |=> (!acc_err && sel != '0)) else $error("cpu refused"); // R7

  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (req && !sw_rst && master_id == 3'd0 && addr >= 24'hFE0000) |=>
      (sel == ($past(rom_dis) ? 9'h100 : 9'h008))) else $error("rom window wrong"); // R2 R10

  AST_BLK_RAM_ONLY: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (blk_idx != '0) |-> (sel[1] || sel[2])) else $error("index outside ram"); // R3

endmodule

bind mmap_decode mmap_decode_chk u_chk (
  .clk        (clk),
  .hw_rst_n   (hw_rst_n),
  .sw_rst     (sw_rst),
  .req        (req),
  .master_id  (master_id),
  .addr       (addr),
  .rom_dis_we (rom_dis_we),
  .rom_dis    (rom_dis),
  .sel        (sel),
  .blk_idx    (blk_idx),
  .acc_err    (acc_err)
);

// File: tb/mmap_decode_bench.sv
`timescale 1ns/1ps
module mmap_decode_bench;

  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  master_id = 3'd0;
  logic [23:0] addr = 24'h0;
  logic        rom_dis_we = 1'b0;
  logic        rom_dis_wdata = 1'b0;
  logic [8:0]  sel;
  logic [4:0]  blk_idx;
  logic        acc_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmap_decode u_mmap_decode (
    .clk           (clk),
    .hw_rst_n      (hw_rst_n),
    .sw_rst        (sw_rst),
    .req           (req),
    .master_id     (master_id),
    .addr          (addr),
    .rom_dis_we    (rom_dis_we),
    .rom_dis_wdata (rom_dis_wdata),
    .sel           (sel),
    .blk_idx       (blk_idx),
    .acc_err       (acc_err)
  );

  // {req tag, master, addr, expected sel, expected index, expected error}
  localparam int NV = 25;
  localparam logic [45:0] VEC [NV] = '{
    {4'd1, 3'd0, 24'h000000, 9'h001, 5'd0,  1'b0}, // R1 register window low edge
    {4'd1, 3'd0, 24'h0000BF, 9'h001, 5'd0,  1'b0}, // R1 register window top
    {4'd1, 3'd0, 24'h0000C0, 9'h002, 5'd0,  1'b0}, // R1 dual RAM start
    {4'd3, 3'd0, 24'h00FFFF, 9'h002, 5'd7,  1'b0}, // R3 last dual block
    {4'd3, 3'd0, 24'h010000, 9'h004, 5'd0,  1'b0}, // R3 first single block
    {4'd3, 3'd0, 24'h04FFFF, 9'h004, 5'd31, 1'b0}, // R3 last single block
    {4'd3, 3'd0, 24'h02A000, 9'h004, 5'd13, 1'b0}, // R3 middle single block
    {4'd1, 3'd0, 24'h050000, 9'h010, 5'd0,  1'b0}, // R1 CS0 start
    {4'd1, 3'd0, 24'h7FFFFF, 9'h010, 5'd0,  1'b0}, // R1 CS0 end
    {4'd1, 3'd0, 24'h800000, 9'h020, 5'd0,  1'b0}, // R1 CS2
    {4'd1, 3'd0, 24'hC00000, 9'h040, 5'd0,  1'b0}, // R1 CS3
    {4'd1, 3'd0, 24'hE00000, 9'h080, 5'd0,  1'b0}, // R1 CS4
    {4'd1, 3'd0, 24'hF00000, 9'h100, 5'd0,  1'b0}, // R1 CS5
    {4'd1, 3'd0, 24'hFDFFFF, 9'h100, 5'd0,  1'b0}, // R1 CS5 below ROM
    {4'd2, 3'd0, 24'hFE0000, 9'h008, 5'd0,  1'b0}, // R2 ROM start
    {4'd2, 3'd0, 24'hFFFFFF, 9'h008, 5'd0,  1'b0}, // R2 ROM end
    {4'd5, 3'd1, 24'h050000, 9'h000, 5'd0,  1'b1}, // R5 DMA0 external
    {4'd5, 3'd3, 24'hFE0000, 9'h008, 5'd0,  1'b0}, // R5 DMA2 internal ROM
    {4'd5, 3'd2, 24'h00F000, 9'h002, 5'd7,  1'b0}, // R5 DMA1 dual RAM
    {4'd7, 3'd4, 24'hC00000, 9'h040, 5'd0,  1'b0}, // R7 DMA3 external
    {4'd6, 3'd5, 24'h001000, 9'h000, 5'd0,  1'b1}, // R6 USB dual RAM
    {4'd6, 3'd6, 24'h030000, 9'h004, 5'd16, 1'b0}, // R6 LCD single RAM
    {4'd6, 3'd6, 24'h000010, 9'h001, 5'd0,  1'b0}, // R6 LCD register window
    {4'd7, 3'd7, 24'h010000, 9'h000, 5'd0,  1'b1}, // R7 unused ID
    {4'd6, 3'd5, 24'h800000, 9'h020, 5'd0,  1'b0}  // R6 USB external
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [8:0] es, input logic [4:0] eb, input logic ee);
    chk({tag, " sel"}, 32'(sel), 32'(es));
    chk({tag, " idx"}, 32'(blk_idx), 32'(eb));
    chk({tag, " err"}, 32'(acc_err), 32'(ee));
  endtask

  // drive one request for one cycle; outputs are checked at the following negedge
  task automatic issue(input logic [2:0] id, input logic [23:0] a);
    @(negedge clk);
    req = 1'b1; master_id = id; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R8 reset state", 9'h0, 5'd0, 1'b0);
    hw_rst_n = 1'b1;
    @(negedge clk);
    chk_out("R4 idle", 9'h0, 5'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][41:39], VEC[i][38:15]);
      chk_out($sformatf("R%0d vec%0d", VEC[i][45:42], i), VEC[i][14:6], VEC[i][5:1], VEC[i][0]);
    end

    @(negedge clk);
    chk_out("R4 quiet after request", 9'h0, 5'd0, 1'b0);

    // R10: write in the same cycle as a ROM request uses the old value
    @(negedge clk);
    req = 1'b1; master_id = 3'd0; addr = 24'hFE0000;
    rom_dis_we = 1'b1; rom_dis_wdata = 1'b1;
    @(negedge clk);
    req = 1'b0; rom_dis_we = 1'b0;
    chk_out("R10 same-cycle write", 9'h008, 5'd0, 1'b0);
    issue(3'd0, 24'hFE0000);
    chk_out("R2 R10 ROM remapped to CS5", 9'h100, 5'd0, 1'b0);
    issue(3'd1, 24'hFF0000);
    chk_out("R5 DMA0 to remapped ROM", 9'h000, 5'd0, 1'b1);
    issue(3'd4, 24'hFF0000);
    chk_out("R7 DMA3 to remapped ROM", 9'h100, 5'd0, 1'b0);

    // R9: software reset clears outputs even with a request present
    @(negedge clk);
    req = 1'b1; master_id = 3'd0; addr = 24'h010000; sw_rst = 1'b1;
    @(negedge clk);
    req = 1'b0; sw_rst = 1'b0;
    chk_out("R9 sw reset over request", 9'h0, 5'd0, 1'b0);
    @(negedge clk);
    req = 1'b1; master_id = 3'd7; addr = 24'h000000; sw_rst = 1'b1;
    @(negedge clk);
    req = 1'b0; sw_rst = 1'b0;
    chk_out("R9 sw reset over error", 9'h0, 5'd0, 1'b0);
    issue(3'd0, 24'hFE0000);
    chk_out("R9 rom bit kept", 9'h100, 5'd0, 1'b0);

    // R8: hardware reset clears the bit and beats a simultaneous write
    @(negedge clk);
    hw_rst_n = 1'b0; rom_dis_we = 1'b1; rom_dis_wdata = 1'b1;
    @(negedge clk);
    chk_out("R8 outputs in reset", 9'h0, 5'd0, 1'b0);
    hw_rst_n = 1'b1; rom_dis_we = 1'b0;
    issue(3'd0, 24'hFE0000);
    chk_out("R8 reset beats write", 9'h008, 5'd0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule